// File: doc/BRIEF.md
# Byte Read Window Accumulator

This block sits beside a padded byte stream, one byte per accepted row, and gathers read windows of 1 to 32 consecutive bytes. Each window is packed little-endian into eight 32-bit result words. A read length is taken from a side input on the first row of each window. A down-counting offset, together with the byte's position inside the window, picks the result word and the byte lane that receive each byte.

When the offset reaches zero, or when the string ends first, the window closes. One cycle later the block raises a single-cycle strobe carrying:

- the string address,
- the read length,
- the eight words, which include the closing row's byte,
- the window's start position inside the string, computed as length − remaining − read length + 1 from the closing row's values.

A validity flag on the strobe is cleared when the closing row lies inside the final, padding-bearing block of the string. The stage upstream supplies the byte, a valid qualifier, the string address, the original length, the signed remaining count, an end-of-string flag and a final-block flag.

Top module: `rdwin_gather`

## Requirements
- R1: After reset, out_valid, out_ok and out_len are 0, and out_words is all zero.
- R2: rd_len is sampled only on the first accepted row of a window: after reset, or on the row after a window closed. On every other row its value has no effect on the length that is reported.
- R3: With no early end, a window of length N closes on its N-th accepted row. out_valid is 1 for exactly one cycle, in the cycle after that row's clock edge. At all other times it is 0.
- R4: The byte at position k of a window (k = 0 for the first byte) lands in word k/4 at bits [8*(k%4)+7 : 8*(k%4)]. Word w occupies out_words[32*w+31 : 32*w]. All bytes not written are 0. For example, the bytes 10,ef,02,1f,6e,6e,1a,11,00,ff give the words 0x1f02ef10, 0x111a6e6e and 0x0000ff00.
- R5: After a window closes, the accumulated words restart from zero, so a following 2-byte window of 55,73 reports word 0 = 0x00007355 and all other words 0.
- R6: On the strobe, out_pos equals (in_len − in_rem − out_len + 1) modulo 2^LEN_W, taken from the closing row. out_addr equals that row's in_addr.
- R7: An accepted row with in_last_hash = 1 always closes the window. out_len keeps the requested length, and only the bytes received so far are filled.
- R8: out_ok is 1 on the strobe exactly when in_final_blk was 0 on the closing row.
- R9: Rows with in_valid = 0 produce no strobe. They neither advance the window nor add a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row qualifier for the byte stream |
| in_byte | input | 8 | Padded stream byte |
| in_addr | input | ADDR_W | Index of the string the row belongs to |
| in_len | input | LEN_W | Original (unpadded) string length |
| in_rem | input | LEN_W+1 | Signed remaining count for this row |
| in_last_hash | input | 1 | Row is the final row of the string |
| in_final_blk | input | 1 | Row lies inside the string's final block |
| rd_len | input | RL_W | Requested window length, 1 to MAX_RD |
| out_valid | output | 1 | Single-cycle result strobe |
| out_ok | output | 1 | Result is outside the final block |
| out_addr | output | ADDR_W | String address of the result |
| out_pos | output | LEN_W | Start position of the window |
| out_len | output | RL_W | Window length |
| out_words | output | 32*MAX_RD/4 | Packed little-endian result words |

## Verification
The assertions assume two things about the inputs. First, rd_len lies between 1 and MAX_RD on every row that opens a window. Second, in_final_blk and in_last_hash are stable, meaningful flags on each accepted row. The stimulus satisfies both: every opening length comes from the 1 to 32 sweep or from fixed legal values. On rows inside a window, rd_len is driven with other legal lengths rather than out-of-range codes, so the range property stays meaningful while still showing that mid-window values are ignored.

// File: rtl/rdwin_pkg.sv
package rdwin_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rdwin_ctrl.sv
module rdwin_ctrl #(
    parameter  int MAX_RD = 32,
    localparam int RL_W   = $clog2(MAX_RD + 1),
    localparam int OFF_W  = $clog2(MAX_RD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last_hash,
    input  logic [RL_W-1:0]  rd_len,
    output logic [RL_W-1:0]  cur_len,
    output logic [OFF_W-1:0] cur_idx,
    output logic             latch
);
    typedef struct packed {
        logic             start;
        logic [OFF_W-1:0] off;
        logic [RL_W-1:0]  len;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [RL_W-1:0]  len_m1;
    logic [OFF_W-1:0] cur_off;

    always_comb begin
        ctrl_d  = ctrl_q;
        cur_len = ctrl_q.start ? rd_len : ctrl_q.len;
        len_m1  = cur_len - 1'b1;
        // offset counts down from length-1; first row reloads it
        cur_off = ctrl_q.start ? len_m1[OFF_W-1:0] : ctrl_q.off;
        cur_idx = len_m1[OFF_W-1:0] - cur_off;
        latch   = in_valid && ((cur_off == '0) || in_last_hash);
        if (in_valid) begin
            ctrl_d.start = latch;
            ctrl_d.off   = cur_off - 1'b1;
            ctrl_d.len   = cur_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{start: 1'b1, off: '0, len: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/rdwin_lane.sv
module rdwin_lane
    import rdwin_pkg::*;
#(
    parameter  int MAX_RD    = 32,
    localparam int OFF_W     = $clog2(MAX_RD),
    localparam int NUM_WORDS = MAX_RD / WORD_BYTES,
    localparam int WSEL_W    = OFF_W - 2
) (
    input  logic [OFF_W-1:0]     idx,
    output logic [NUM_WORDS-1:0] word_sel,
    output logic [WORD_BYTES-1:0] lane_sel
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_sel[w] = (idx[OFF_W-1:2] == WSEL_W'(w));
    end
    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        assign lane_sel[l] = (idx[1:0] == 2'(l));
    end
endmodule

// File: rtl/rdwin_acc.sv
module rdwin_acc
    import rdwin_pkg::*;
#(
    parameter  int MAX_RD    = 32,
    localparam int NUM_WORDS = MAX_RD / WORD_BYTES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        latch,
    input  byte_t                       in_byte,
    input  logic [NUM_WORDS-1:0]        word_sel,
    input  logic [WORD_BYTES-1:0]       lane_sel,
    output logic [NUM_WORDS*WORD_W-1:0] cur_words
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] acc_d, acc_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] acc_add;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_t weighted;
        always_comb begin
            weighted = '0;
            for (int l = 0; l < WORD_BYTES; l++) begin
                if (in_valid && word_sel[w] && lane_sel[l]) begin
                    weighted = word_t'(in_byte) << (BYTE_W * l);
                end
            end
            acc_add[w] = acc_q[w] + weighted;
        end
        assign cur_words[w*WORD_W +: WORD_W] = acc_add[w];
    end

    always_comb begin
        acc_d = acc_q;
        if (latch) begin
            acc_d = '0;
        end else if (in_valid) begin
            acc_d = acc_add;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/rdwin_gather.sv
module rdwin_gather
    import rdwin_pkg::*;
#(
    parameter  int MAX_RD    = 32,
    parameter  int ADDR_W    = 16,
    parameter  int LEN_W     = 16,
    localparam int RL_W      = $clog2(MAX_RD + 1),
    localparam int OFF_W     = $clog2(MAX_RD),
    localparam int NUM_WORDS = MAX_RD / WORD_BYTES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [BYTE_W-1:0]           in_byte,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [LEN_W-1:0]            in_len,
    input  logic signed [LEN_W:0]       in_rem,
    input  logic                        in_last_hash,
    input  logic                        in_final_blk,
    input  logic [RL_W-1:0]             rd_len,
    output logic                        out_valid,
    output logic                        out_ok,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [LEN_W-1:0]            out_pos,
    output logic [RL_W-1:0]             out_len,
    output logic [NUM_WORDS*WORD_W-1:0] out_words
);
    typedef struct packed {
        logic                        valid;
        logic                        ok;
        logic [ADDR_W-1:0]           addr;
        logic [LEN_W-1:0]            pos;
        logic [RL_W-1:0]             len;
        logic [NUM_WORDS*WORD_W-1:0] words;
    } res_t;

    res_t res_d, res_q;

    logic [RL_W-1:0]             cur_len;
    logic [OFF_W-1:0]            cur_idx;
    logic                        latch;
    logic [NUM_WORDS-1:0]        word_sel;
    logic [WORD_BYTES-1:0]       lane_sel;
    logic [NUM_WORDS*WORD_W-1:0] cur_words;
    logic signed [LEN_W:0]       start_pos;

    rdwin_ctrl #(.MAX_RD(MAX_RD)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_last_hash (in_last_hash),
        .rd_len       (rd_len),
        .cur_len      (cur_len),
        .cur_idx      (cur_idx),
        .latch        (latch)
    );

    rdwin_lane #(.MAX_RD(MAX_RD)) i_lane (
        .idx      (cur_idx),
        .word_sel (word_sel),
        .lane_sel (lane_sel)
    );

    rdwin_acc #(.MAX_RD(MAX_RD)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .latch     (latch),
        .in_byte   (in_byte),
        .word_sel  (word_sel),
        .lane_sel  (lane_sel),
        .cur_words (cur_words)
    );

    always_comb begin
        // first byte index = length - remaining - window length + 1
        start_pos = $signed({1'b0, in_len}) - in_rem
                  - $signed({{(LEN_W + 1 - RL_W){1'b0}}, cur_len})
                  + $signed((LEN_W + 1)'(1));
        res_d       = res_q;
        res_d.valid = latch;
        if (latch) begin
            res_d.ok    = !in_final_blk;
            res_d.addr  = in_addr;
            res_d.pos   = start_pos[LEN_W-1:0];
            res_d.len   = cur_len;
            res_d.words = cur_words;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_ok    = res_q.ok;
    assign out_addr  = res_q.addr;
    assign out_pos   = res_q.pos;
    assign out_len   = res_q.len;
    assign out_words = res_q.words;
endmodule

// File: rtl/rdwin_gather_chk.sv
module rdwin_gather_chk #(
    parameter  int MAX_RD = 32,
    localparam int RL_W   = $clog2(MAX_RD + 1),
    localparam int NWB    = 32 * (MAX_RD / 4)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_last_hash,
    input logic            in_final_blk,
    input logic            out_valid,
    input logic            out_ok,
    input logic [RL_W-1:0] out_len,
    input logic [NWB-1:0]  out_words
);
    // R7
    forced_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_last_hash |=> out_valid);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R8
    ok_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ok == !$past(in_final_blk)));
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_len <= RL_W'(4)) |-> (out_words[NWB-1:32] == '0));
    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= RL_W'(1)) && (out_len <= RL_W'(MAX_RD)));
endmodule

bind rdwin_gather rdwin_gather_chk #(.MAX_RD(MAX_RD)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_last_hash (in_last_hash),
    .in_final_blk (in_final_blk),
    .out_valid    (out_valid),
    .out_ok       (out_ok),
    .out_len      (out_len),
    .out_words    (out_words)
);

// File: tb/test_rdwin_gather.sv
module test_rdwin_gather;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = '0;
    logic [15:0]  in_addr = '0;
    logic [15:0]  in_len = '0;
    logic signed [16:0] in_rem = '0;
    logic         in_last_hash = 1'b0;
    logic         in_final_blk = 1'b0;
    logic [5:0]   rd_len = 6'd1;
    logic         out_valid, out_ok;
    logic [15:0]  out_addr, out_pos;
    logic [5:0]   out_len;
    logic [255:0] out_words;

    int checks = 0;
    int failures = 0;

    // bench model of the open window
    logic        b_active = 1'b0;
    int          b_len = 0;
    int          b_cnt = 0;
    logic [255:0] b_w = '0;
    logic [255:0] last_words = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdwin_gather i_rdwin_gather (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_addr(in_addr), .in_len(in_len), .in_rem(in_rem),
        .in_last_hash(in_last_hash), .in_final_blk(in_final_blk),
        .rd_len(rd_len), .out_valid(out_valid), .out_ok(out_ok),
        .out_addr(out_addr), .out_pos(out_pos), .out_len(out_len),
        .out_words(out_words)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one row at a falling edge, check result at the next falling edge
    task automatic step(input logic v, input logic [7:0] by, input logic [15:0] a,
                        input int L, input int rem, input logic lh, input logic fb,
                        input int rdl);
        logic done = 1'b0;
        int   exp_pos = 0;
        int   used_len = 0;
        in_valid = v; in_byte = by; in_addr = a; in_len = 16'(L);
        in_rem = 17'(rem); in_last_hash = lh; in_final_blk = fb; rd_len = 6'(rdl);
        if (v) begin
            if (!b_active) begin
                b_len = rdl; b_cnt = 0; b_w = '0; b_active = 1'b1;   // R2 R5
            end
            b_w[b_cnt*8 +: 8] = by;                                 // R4
            b_cnt++;
            done = (b_cnt == b_len) || lh;                           // R3 R7
            exp_pos = L - rem - b_len + 1;
            used_len = b_len;
        end
        @(negedge clk);
        chk(out_valid == done, "R3 R9 strobe", 256'(out_valid), 256'(done));
        if (done) begin
            last_words = out_words;
            chk(out_len == 6'(used_len), "R2 length", 256'(out_len), 256'(used_len));
            chk(out_words == b_w, "R4 R5 words", out_words, b_w);
            chk(out_pos == 16'(exp_pos), "R6 position", 256'(out_pos), 256'(16'(exp_pos)));
            chk(out_addr == a, "R6 address", 256'(out_addr), 256'(a));
            chk(out_ok == !fb, "R8 ok flag", 256'(out_ok), 256'(!fb));
            b_active = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] ex [12] = '{8'h10, 8'hef, 8'h02, 8'h1f, 8'h6e, 8'h6e,
                                8'h1a, 8'h11, 8'h00, 8'hff, 8'h55, 8'h73};
        int row;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 valid", 256'(out_valid), 256'(0));
        chk(out_ok == 1'b0, "R1 ok", 256'(out_ok), 256'(0));
        chk(out_len == '0, "R1 len", 256'(out_len), 256'(0));
        chk(out_words == '0, "R1 words", out_words, 256'(0));
        rst_n = 1'b1;

        // worked example: 10-byte window then 2-byte window (R4 R5)
        for (int i = 0; i < 12; i++) begin
            step(1'b1, ex[i], 16'd6, 12, 12 - i, i == 11, 1'b0,
                 (i == 0) ? 10 : ((i == 10) ? 2 : 7));
            if (i == 9)
                chk(last_words[95:0] == 96'h0000ff00_111a6e6e_1f02ef10, "R4 example",
                    256'(last_words[95:0]), 256'(96'h0000ff00_111a6e6e_1f02ef10));
            if (i == 11)
                chk(last_words == 256'h7355, "R5 example", last_words, 256'h7355);
        end

        // sweep every length 1..32 in one string, with idle rows (R9)
        // and other legal lengths on mid-window rows (R2)
        row = 0;
        for (int n = 1; n <= 32; n++) begin
            for (int k = 0; k < n; k++) begin
                if ((row % 5) == 3)
                    step(1'b0, 8'hee, 16'd1, 528, 0, 1'b1, 1'b1, 1);
                step(1'b1, 8'((row * 37 + 5) & 255), 16'd1, 528, 528 - row,
                     row == 527, 1'b0, (k == 0) ? n : (((n + k) % 32) + 1));
                row++;
            end
        end

        // R7 string ends before a 10-byte window is full
        for (int i = 0; i < 6; i++)
            step(1'b1, 8'(i + 8'ha0), 16'd2, 6, 6 - i, i == 5, 1'b0,
                 (i == 0) ? 10 : 4);

        // R8 window inside the final block, new length after string start
        for (int i = 0; i < 3; i++)
            step(1'b1, 8'(i + 8'h30), 16'd3, 3, 3 - i, i == 2, 1'b1, 3);

        step(1'b0, 8'h00, 16'd0, 0, 0, 1'b0, 1'b0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule